// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash interface and decides whether a program or erase operation in the memory has finished. The memory signals that it is busy by flipping one status bit each time its status word is read, and it raises a second status bit when its internal operation has exceeded its limits. The poller reads the status word in back-to-back pairs at one address and compares the busy bit between the two reads of each pair.

After a start pulse the block latches the address and issues reads over a plain request/acknowledge port. A pair whose busy bit matches means the operation has ended successfully. A pair whose busy bit differs leads to a look at the limit bit of the newer read. When that bit is clear, polling goes on. When it is set, one more confirming pair is read, because the busy bit may have stopped flipping at the moment the limit bit rose. A confirming pair that still differs ends in failure. The outcome is given as a single-cycle done pulse, together with either pass or fail. The memory may take any number of cycles to acknowledge a read.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After reset, rd_req_o, busy_o, done_o, pass_o and fail_o are all low.
- R2: start_i in the idle state latches addr_i. Reads are then issued in pairs, each at that latched address. rd_addr_o stays constant for the whole operation, even if addr_i changes.
- R3: When bit 6 (TOGGLE_BIT) of the two reads of a pair is equal, the operation ends with pass. The other bits of the status word have no effect.
- R4: When bit 6 differs within a pair and bit 5 (ERR_BIT) of the second read of the pair is 0, another pair is read. Bit 5 of the first read has no effect.
- R5: When bit 6 differs and bit 5 of the second read is 1, exactly one confirming pair is read. If bit 6 is equal in that pair, the result is pass.
- R6: If bit 6 differs in the confirming pair, the result is fail, whatever bit 5 holds in that pair.
- R7: done_o is high for exactly one cycle per operation. Exactly one of pass_o or fail_o is high with it, and both are low whenever done_o is low.
- R8: busy_o is high from the cycle after an accepted start up to and including the done cycle. Any start_i seen while busy_o is high is ignored.
- R9: A read completes only in a cycle where rd_req_o and rd_ack_i are both high. rd_data_i is captured only in that cycle, and rd_req_o stays high until the read completes, so any acknowledge latency is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| addr_i | input | ADDR_W | Address to poll, latched at start |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| rd_data_i | input | DATA_W | Status word returned by the memory |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded (with done_o) |
| fail_o | output | 1 | Operation failed (with done_o) |

## Verification
The assertions assume that the memory raises rd_ack_i only while rd_req_o is high, that each acknowledge cycle completes exactly one read, and that rd_data_i is meaningful only in that cycle. The bench's memory model acknowledges only outstanding requests and can add a chosen number of wait cycles first. It holds each acknowledge for a single cycle. Outside acknowledge cycles it drives a status word whose bit 6 flips every cycle, so sampling at the wrong time would change the outcome. Each scenario loads exactly the status words it expects to be consumed, and the bench checks afterwards that none were left over or missing.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL,
    ST_DONE
  } poll_state_e;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_FAIL,
    ACT_AGAIN,
    ACT_CONFIRM
  } verdict_e;
endpackage

// File: rtl/tbp_sample_pair.sv
module tbp_sample_pair #(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int ERR_BIT    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              toggled_o,
  output logic              err_o
);
  logic tog_a_q, tog_b_q, err_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_a_q <= 1'b0;
      tog_b_q <= 1'b0;
      err_b_q <= 1'b0;
    end else begin
      if (cap_a_i) tog_a_q <= data_i[TOGGLE_BIT];
      if (cap_b_i) begin
        tog_b_q <= data_i[TOGGLE_BIT];
        err_b_q <= data_i[ERR_BIT];  // limit bit of the newer read only
      end
    end
  end

  assign toggled_o = tog_a_q ^ tog_b_q;
  assign err_o     = err_b_q;
endmodule

// File: rtl/tbp_verdict.sv
module tbp_verdict
  import tbp_pkg::*;
(
  input  logic     toggled_i,
  input  logic     err_i,
  input  logic     confirm_i,
  output verdict_e verdict_o
);
  always_comb begin
    if (!toggled_i)     verdict_o = ACT_PASS;
    else if (confirm_i) verdict_o = ACT_FAIL;
    else if (err_i)     verdict_o = ACT_CONFIRM;
    else                verdict_o = ACT_AGAIN;
  end
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl
  import tbp_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int ERR_BIT    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  poll_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              confirm_q, confirm_d;
  logic              pass_q, pass_d;
  logic              xfer, toggled, err;
  verdict_e          verdict;
  logic              unused_data;

  assign unused_data = ^rd_data_i;
  assign rd_req_o    = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign xfer        = rd_req_o && rd_ack_i;

  tbp_sample_pair #(
    .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .ERR_BIT(ERR_BIT)
  ) u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_a_i  (xfer && state_q == ST_RD_A),
    .cap_b_i  (xfer && state_q == ST_RD_B),
    .data_i   (rd_data_i),
    .toggled_o(toggled),
    .err_o    (err)
  );

  tbp_verdict u_verdict (
    .toggled_i(toggled),
    .err_i    (err),
    .confirm_i(confirm_q),
    .verdict_o(verdict)
  );

  always_comb begin
    state_d   = state_q;
    confirm_d = confirm_q;
    pass_d    = pass_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_RD_A;
        confirm_d = 1'b0;
      end
      ST_RD_A: if (xfer) state_d = ST_RD_B;
      ST_RD_B: if (xfer) state_d = ST_EVAL;
      ST_EVAL: begin
        unique case (verdict)
          ACT_PASS:    begin pass_d = 1'b1; state_d = ST_DONE; end
          ACT_FAIL:    begin pass_d = 1'b0; state_d = ST_DONE; end
          ACT_CONFIRM: begin confirm_d = 1'b1; state_d = ST_RD_A; end
          default:     state_d = ST_RD_A;
        endcase
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      confirm_q <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      confirm_q <= confirm_d;
      pass_q    <= pass_d;
      if (state_q == ST_IDLE && start_i) addr_q <= addr_i;
    end
  end

  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign pass_o    = done_o && pass_q;
  assign fail_o    = done_o && !pass_q;
endmodule

// File: rtl/tbp_poll_ctrl_chk.sv
module tbp_poll_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  logic [15:0] reads_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reads_q <= '0;
    else if (!busy_o && start_i) reads_q <= '0;
    else if (rd_req_o && rd_ack_i) reads_q <= reads_q + 16'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !done_o);

  assert_addr_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(rd_addr_o));

  assert_even_pairs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> reads_q >= 16'd2 && !reads_q[0]);

  assert_one_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({pass_o, fail_o}) == 1);

  assert_no_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !pass_o && !fail_o);

  assert_single_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i |=> busy_o);

  assert_req_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);

  assert_req_in_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o && !done_o);
endmodule

bind tbp_poll_ctrl tbp_poll_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_ack_i (rd_ack_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .fail_o   (fail_o)
);

// File: tb/tbp_poll_ctrl_test.sv
module tbp_poll_ctrl_test;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_ack_i = 1'b0;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              busy_o, done_o, pass_o, fail_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]        mem_q[$];
  int                lat = 0;
  int                wait_cnt = 0;
  int                n_reads = 0;
  int                n_bad_addr = 0;
  int                n_underflow = 0;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic              junk = 1'b0;

  always #2 clk_i = ~clk_i;

  tbp_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .fail_o(fail_o)
  );

  // memory model: acks outstanding requests after lat wait cycles
  initial begin
    forever begin
      @(negedge clk_i);
      junk = ~junk;
      rd_ack_i = 1'b0;
      rd_data_i = {1'b1, junk, 6'h15};  // bit 6 flips when not acked
      if (rd_req_o) begin
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          rd_ack_i = 1'b1;
          n_reads++;
          if (rd_addr_o !== exp_addr) n_bad_addr++;
          if (mem_q.size() == 0) begin
            n_underflow++;
            rd_data_i = 8'h00;
          end else rd_data_i = mem_q.pop_front();
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // run one operation on the words already in mem_q
  task automatic run_op(input string req, input logic [ADDR_W-1:0] a,
                        input int latency, input bit exp_pass, input int exp_reads,
                        input bit poke_start);
    int cyc;
    bit seen;
    lat = latency;
    wait_cnt = 0;
    n_reads = 0;
    n_bad_addr = 0;
    n_underflow = 0;
    exp_addr = a;
    @(negedge clk_i);
    addr_i = a;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    addr_i = ~a;
    check(busy_o === 1'b1, "R8", "busy after start", busy_o, 1);
    seen = 1'b0;
    for (cyc = 0; cyc < 2000 && !seen; cyc++) begin
      if (done_o) seen = 1'b1;
      else begin
        if (poke_start && cyc == 3) begin
          start_i = 1'b1;
          addr_i = a ^ 24'h00F0F0;
        end else start_i = 1'b0;
        @(negedge clk_i);
      end
    end
    start_i = 1'b0;
    check(seen, req, "done seen", seen, 1);
    check(pass_o === exp_pass && fail_o === !exp_pass, req, "pass flag",
          pass_o, exp_pass);
    check(n_reads == exp_reads, req, "read count", n_reads, exp_reads);
    check(n_bad_addr == 0, "R2", "reads at wrong address", n_bad_addr, 0);
    check(mem_q.size() == 0 && n_underflow == 0, req, "words consumed",
          mem_q.size() + n_underflow, 0);
    @(negedge clk_i);
    check(!done_o && !pass_o && !fail_o, "R7", "done one cycle", done_o, 0);
    repeat (6) @(negedge clk_i);
    check(!busy_o && !rd_req_o && n_reads == exp_reads, "R8", "idle after done",
          n_reads, exp_reads);
  endtask

  task automatic t_reset();
    check(!rd_req_o && !busy_o && !done_o && !pass_o && !fail_o, "R1",
          "reset outputs", {rd_req_o, busy_o, done_o, pass_o, fail_o}, 0);
  endtask

  task automatic t_quick_pass();
    mem_q = '{8'h00, 8'h00};
    run_op("R3", 24'h000100, 0, 1'b1, 2, 1'b0);
    mem_q = '{8'hDF, 8'h5F};  // other bits differ, bit 6 equal
    run_op("R3", 24'h3FFFFE, 1, 1'b1, 2, 1'b0);
  endtask

  task automatic t_loop();
    mem_q = '{8'h40, 8'h00, 8'h00, 8'h00};
    run_op("R4", 24'h000200, 0, 1'b1, 4, 1'b0);
    mem_q = '{8'h60, 8'h00, 8'h40, 8'h40};  // limit bit only in older read
    run_op("R4", 24'h000300, 0, 1'b1, 4, 1'b0);
  endtask

  task automatic t_confirm_pass();
    mem_q = '{8'h00, 8'h60, 8'h60, 8'h60};
    run_op("R5", 24'h012345, 0, 1'b1, 4, 1'b0);
  endtask

  task automatic t_confirm_fail();
    mem_q = '{8'h00, 8'h60, 8'h20, 8'h60};
    run_op("R6", 24'h0ABCDE, 0, 1'b0, 4, 1'b0);
    mem_q = '{8'h40, 8'h20, 8'h40, 8'h00};  // limit bit clear in confirm pair
    run_op("R6", 24'h0ABCE0, 0, 1'b0, 4, 1'b0);
  endtask

  task automatic t_latency();
    mem_q = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h60, 8'h60, 8'h20};
    run_op("R9", 24'h155555, 3, 1'b0, 8, 1'b0);
    mem_q = '{8'h40, 8'h00, 8'h00, 8'h00};
    run_op("R9", 24'h2AAAAA, 5, 1'b1, 4, 1'b0);
  endtask

  task automatic t_start_ignored();
    mem_q = '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00};
    run_op("R8", 24'h070707, 2, 1'b1, 6, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_quick_pass();
    t_loop();
    t_confirm_pass();
    t_confirm_fail();
    t_latency();
    t_start_ignored();
    summary();
  end
endmodule